// File: doc/BRIEF.md
# Power-Up Strap Frequency Select Controller

This block decides which entry of a clock synthesizer's frequency table is active. At power-up it keeps a group of dual-purpose pins in input mode for a fixed number of reference clock cycles. At the end of that window it takes one sample of their levels as configuration straps: a 5-bit hardware frequency code, the IOAPIC divider choice and the super-I/O clock choice. After that the pins go back to being clock outputs, and their levels no longer affect anything.

Once the window has closed, a mode bit in the control byte chooses the source of the table index. The first source is the hardware strap code, zero-extended to 6 bits, which reaches the lower 32 table entries. The second is a 6-bit software code whose bits are scattered within the control byte, and which reaches all 64 entries, including the upper half that runs to about 200 MHz. The index is held in a register. A one-cycle pulse marks each change so that the synthesizer can move to the new frequency smoothly.

Top module: `freq_sel_ctrl`

## Requirements
- R1: After reset is released, `strap_phase_o` stays 1 for exactly `STRAP_WIN` rising clock edges. It then goes to 0 and stays 0 until the next reset. It is also 1 while reset is asserted.
- R2: The straps are sampled on the clock edge that ends the window. FS0, FS2 and FS3 (`pin_fs_i` bits 0, 2 and 3) take the pin level. FS1 and FS4 (bits 1 and 4) come from active-low pins and take the inverted level. `apic_half_o` takes `pin_apic_i`, where 1 means the IOAPIC clock runs at half the PCI rate and 0 means it runs at the PCI rate. `sio_24m_o` takes `pin_sio_i`, where 1 means 24 MHz and 0 means 48 MHz.
- R3: After the window, changes on `pin_fs_i`, `pin_apic_i` or `pin_sio_i` have no effect on any output.
- R4: During reset the outputs show the values of floating straps: `tbl_idx_o` = 13 (FS4..FS0 = 01101), `apic_half_o` = 1, `sio_24m_o` = 1, `idx_chg_o` = 0.
- R5: When `cfg_sel_i[3]` = 0 (hardware mode), `tbl_idx_o` becomes {0, FS4..FS0} one clock edge later. Bit 5 of the index is always 0 in this mode.
- R6: When `cfg_sel_i[3]` = 1 (software mode), `tbl_idx_o` becomes {`cfg_sel_i[1]`, `cfg_sel_i[2]`, `cfg_sel_i[7:4]`} one clock edge later. These are the software select bits 5 down to 0.
- R7: While `strap_phase_o` is 1, `tbl_idx_o` keeps its reset value and `cfg_sel_i` is ignored.
- R8: `idx_chg_o` is 1 for the cycle right after a clock edge at which `tbl_idx_o` changed value, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_fs_i | input | 5 | Levels on the frequency-select strap pins; bits 1 and 4 are active low |
| pin_apic_i | input | 1 | Level on the IOAPIC divider strap pin |
| pin_sio_i | input | 1 | Level on the super-I/O clock strap pin |
| cfg_sel_i | input | 8 | Control byte: bit 3 = source, bits 7:4, 2 and 1 = software code |
| tbl_idx_o | output | 6 | Active frequency table index |
| apic_half_o | output | 1 | Latched IOAPIC select, 1 = half PCI rate |
| sio_24m_o | output | 1 | Latched super-I/O select, 1 = 24 MHz |
| strap_phase_o | output | 1 | Strap sampling window; shared pin drivers stay off while 1 |
| idx_chg_o | output | 1 | One-cycle pulse after the index changes |

## Verification
The strap pins are driven with three patterns: all high (floating pins), all low, and values that change every cycle of the window. Only the all-high case reproduces the default index 13, and only the changing pattern shows whether the sample comes from the final edge of the window and whether bits 1 and 4 are inverted. During and after the window, the control byte is driven with random values that are held for several cycles or changed every cycle. Holding a value separates a real change pulse from a pulse that sticks at 1, and a full sweep of the 64 software codes in software mode exposes any misplaced bit of the scattered field. Toggling the pins after the window shows whether a late capture has slipped through.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  localparam int HW_W  = 5;
  localparam int IDX_W = 6;
  localparam int CFG_W = 8;
  localparam int CFG_MODE_BIT = 3;

  // strap bits whose pin is active low
  localparam logic [HW_W-1:0] FS_INV_MASK = 5'b10010;
  // code seen with every strap pin floating high
  localparam logic [HW_W-1:0] FS_DFLT = 5'b01101;

  typedef struct packed {
    logic [HW_W-1:0] fs;
    logic            apic_half;
    logic            sio_24m;
  } strap_t;

  localparam strap_t STRAP_DFLT = '{fs: FS_DFLT, apic_half: 1'b1, sio_24m: 1'b1};

  function automatic logic [IDX_W-1:0] sw_code(input logic [CFG_W-1:0] cfg);
    return {cfg[1], cfg[2], cfg[7:4]};
  endfunction
endpackage

// File: rtl/strap_window.sv
module strap_window #(
  parameter int WIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic capture_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (phase_q) begin
      if (cnt_q == LAST) phase_q <= 1'b0;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign capture_o = phase_q && (cnt_q == LAST);

  assert_window_closed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_q |=> !phase_q);
  assert_cnt_parked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phase_q) |-> cnt_q == LAST);
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import freq_sel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [HW_W-1:0] pin_fs_i,
  input  logic            pin_apic_i,
  input  logic            pin_sio_i,
  output strap_t          straps_o
);
  logic [HW_W-1:0] fs_lvl;
  strap_t          q;

  for (genvar b = 0; b < HW_W; b++) begin : g_pol
    if (FS_INV_MASK[b]) begin : g_inv
      assign fs_lvl[b] = ~pin_fs_i[b];
    end else begin : g_dir
      assign fs_lvl[b] = pin_fs_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= STRAP_DFLT;
    else if (capture_i) q <= '{fs: fs_lvl, apic_half: pin_apic_i, sio_24m: pin_sio_i};
  end

  assign straps_o = q;

  assert_hold_after_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(q));
  assert_apic_sampled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> q.apic_half == $past(pin_apic_i));
endmodule

// File: rtl/idx_select.sv
module idx_select
  import freq_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_i,
  input  logic             sw_mode_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [HW_W-1:0]  hw_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             chg_o
);
  logic [IDX_W-1:0] idx_nxt, idx_q;
  logic             chg_q;

  assign idx_nxt = sw_mode_i ? sw_idx_i : {{(IDX_W-HW_W){1'b0}}, hw_idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_W'(FS_DFLT);
      chg_q <= 1'b0;
    end else if (phase_i) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= (idx_nxt != idx_q);
      idx_q <= idx_nxt;
    end
  end

  assign idx_o = idx_q;
  assign chg_o = chg_q;

  assert_hold_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> $stable(idx_q));
  assert_hw_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_i && !sw_mode_i) |=> idx_q[IDX_W-1] == 1'b0);
  assert_pulse_on_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> idx_q != $past(idx_q));
  assert_quiet_when_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_q |-> $stable(idx_q));
endmodule

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl
  import freq_sel_pkg::*;
#(
  parameter int STRAP_WIN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HW_W-1:0]  pin_fs_i,
  input  logic             pin_apic_i,
  input  logic             pin_sio_i,
  input  logic [CFG_W-1:0] cfg_sel_i,
  output logic [IDX_W-1:0] tbl_idx_o,
  output logic             apic_half_o,
  output logic             sio_24m_o,
  output logic             strap_phase_o,
  output logic             idx_chg_o
);
  logic   phase, capture;
  strap_t straps;
  logic   unused_cfg;

  assign unused_cfg = cfg_sel_i[0];

  strap_window #(.WIN(STRAP_WIN)) u_window (
    .clk_i, .rst_ni, .phase_o(phase), .capture_o(capture)
  );

  strap_latch u_latch (
    .clk_i, .rst_ni, .capture_i(capture),
    .pin_fs_i, .pin_apic_i, .pin_sio_i, .straps_o(straps)
  );

  idx_select u_sel (
    .clk_i, .rst_ni, .phase_i(phase),
    .sw_mode_i(cfg_sel_i[CFG_MODE_BIT]),
    .sw_idx_i(sw_code(cfg_sel_i)),
    .hw_idx_i(straps.fs),
    .idx_o(tbl_idx_o), .chg_o(idx_chg_o)
  );

  assign apic_half_o   = straps.apic_half;
  assign sio_24m_o     = straps.sio_24m;
  assign strap_phase_o = phase;

  assert_no_pulse_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase |-> !idx_chg_o);
endmodule

// File: tb/freq_sel_ctrl_bench.sv
module freq_sel_ctrl_bench;
  localparam int W = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pin_fs = 5'h1f;
  logic       pin_apic = 1'b1;
  logic       pin_sio = 1'b1;
  logic [7:0] cfg = 8'h00;
  logic [5:0] idx;
  logic       apic, sio, phase, chg;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  freq_sel_ctrl #(.STRAP_WIN(W)) u_freq_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_fs_i(pin_fs), .pin_apic_i(pin_apic),
    .pin_sio_i(pin_sio), .cfg_sel_i(cfg), .tbl_idx_o(idx), .apic_half_o(apic),
    .sio_24m_o(sio), .strap_phase_o(phase), .idx_chg_o(chg)
  );

  // reference model
  int         m_k;
  logic [4:0] m_fs;
  logic       m_apic, m_sio, m_chg;
  logic [5:0] m_idx, nxt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_fs = 5'd13; m_apic = 1; m_sio = 1; m_idx = 6'd13; m_chg = 0;
    end else if (m_k < W) begin
      if (m_k == W - 1) begin
        m_fs   = {~pin_fs[4], pin_fs[3], pin_fs[2], ~pin_fs[1], pin_fs[0]};
        m_apic = pin_apic;
        m_sio  = pin_sio;
      end
      m_chg = 0;
      m_k++;
    end else begin
      nxt   = cfg[3] ? {cfg[1], cfg[2], cfg[7], cfg[6], cfg[5], cfg[4]} : {1'b0, m_fs};
      m_chg = (nxt != m_idx);
      m_idx = nxt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit in_win = (m_k < W);
    if (!rst_n) begin
      chk("R4 idx", idx, 13); chk("R4 apic", apic, 1); chk("R4 sio", sio, 1);
      chk("R4 chg", chg, 0);  chk("R1 phase in reset", phase, 1);
    end else begin
      chk("R1 phase", phase, in_win);
      chk(in_win ? "R7 idx held" : (cfg[3] ? "R6 idx" : "R5 idx"), idx, m_idx);
      chk(in_win ? "R2 apic" : "R3 apic", apic, m_apic);
      chk(in_win ? "R2 sio" : "R3 sio", sio, m_sio);
      chk("R8 chg", chg, m_chg);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int mode);
    // mode 0: pins high, 1: pins low, 2: random each cycle
    rst_n = 1'b0;
    cfg = 8'($urandom);
    pin_fs = (mode == 1) ? 5'h00 : 5'h1f;
    pin_apic = (mode != 1); pin_sio = (mode != 1);
    repeat (3) tick();
    rst_n = 1'b1;
    for (int i = 0; i < W + 2; i++) begin
      tick();
      cfg = 8'($urandom);
      if (mode == 2) begin
        pin_fs = 5'($urandom); pin_apic = 1'($urandom); pin_sio = 1'($urandom);
      end
    end
    for (int i = 0; i < 300; i++) begin
      int hold = $urandom_range(1, 4);
      cfg = 8'($urandom);
      pin_fs = 5'($urandom); pin_apic = 1'($urandom); pin_sio = 1'($urandom);
      repeat (hold) tick();
    end
    cfg = 8'h00;
    repeat (3) tick();
    for (int c = 0; c < 64; c++) begin
      cfg = {c[3:0], 1'b1, c[4], c[5], 1'b0};
      repeat (2) tick();
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(0);
    run(1);
    run(2);
    run(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule